// File: doc/BRIEF.md
# Serial-Loaded Output Configuration Controller

This block is the control logic of an eight-output clock fanout device whose outputs are grouped into four banks (A, B, C, D) of two. A host writes a 10-bit configuration word over a three-wire serial port made of a shift clock, a data line and a latch strobe. The word holds one enable bit per output and two signalling-type bits. The type bits set bank A on its own and banks B to D as one group. A serial readback line returns the bits that leave the shift register, so the host can read back what it wrote.

The shift register and the applied word are separate registers. Bits shift in while the latch strobe is low and the live outputs do not change. The word moves into the holding register on the rising edge of the latch strobe. A global hardware enable pin gates every output enable. A status flag shows when the number of bits shifted before a latch was not exactly ten. All serial pins and the enable pin are sampled by the system clock through a synchronizer. The system clock must run at least four times faster than the shift clock.

Top module: `outcfg_ctrl`

## Requirements
- R1: During and right after reset, `out_en` and `out_pecl` are all zero (disabled, differential low-swing type), `ser_dout` is 0 and `cnt_err` is 0.
- R2: On each rising edge of `ser_clk` seen while `ser_latch` is low, the shift register takes `ser_din` into bit 0 and moves every bit one place up. The first bit shifted is therefore configuration bit D10, which ends in shift-register bit 9.
- R3: While no latch rising edge occurs and `glob_en` does not change, `out_en` and `out_pecl` hold their values, including while bits are being shifted.
- R4: A rising edge of `ser_latch` copies the shift register into the holding register. Holding-register bit k+2 then drives `out_en[k]` for k = 0..7, where outputs 0,1 are bank A, outputs 2,3 bank B, 4,5 bank C and 6,7 bank D.
- R5: Holding-register bit 0 (D1) sets the type of outputs 0 and 1, and bit 1 (D2) sets the type of outputs 2 to 7. The value 1 selects the emitter-coupled high-swing type (`out_pecl` = 1) and 0 selects the low-voltage differential type.
- R6: While `glob_en` is low, every `out_en` bit is 0 whatever the holding register contains. `out_pecl` is not affected.
- R7: `ser_dout` always shows shift-register bit 9. After ten further shifts the host has read the previously held shift-register contents, MSB first.
- R8: On each latch rising edge, `cnt_err` becomes 1 if the number of bits shifted since the previous latch differs from 10, and becomes 0 otherwise. A short or long word is still applied as it stands in the shift register.
- R9: `ser_clk` rising edges seen while `ser_latch` is high shift nothing and are not counted.
- R10: Until the first latch edge after reset, all outputs stay disabled and of the low-voltage differential type, even with `glob_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_latch | input | 1 | Latch strobe; low to shift, rising edge applies |
| glob_en | input | 1 | Global hardware output enable |
| out_en | output | 8 | Per-output enable, index 0 = bank A output 0 |
| out_pecl | output | 8 | Per-output type, 1 = high-swing emitter-coupled |
| ser_dout | output | 1 | Serial readback of shift-register bit 9 |
| cnt_err | output | 1 | Last latch followed a bit count other than 10 |

## Verification
Two events can be resolved in the same system cycle. The first is a latch edge that applies a new word while `glob_en` falls. The bench drives both pins on the same clock edge so that they leave the synchronizer together, then checks that the enables go to zero while the types still take the new word. The second is a shift-clock edge that arrives while the latch is high. The bench toggles the shift clock with the latch held high, then checks that the readback bit, the applied word and the bit count all stay unchanged. A behavioural reference model in the bench follows every cycle and judges both cases.

// File: rtl/outcfg_pkg.sv
package outcfg_pkg;

   // Signalling type of one output driver.
   typedef enum logic {
      SIG_LVDS = 1'b0,
      SIG_PECL = 1'b1
   } sig_type_e;

   // Raw serial and enable pins, carried together through the synchronizer.
   typedef struct packed {
      logic sclk;
      logic sdin;
      logic slat;
      logic gen;
   } pin_bus_t;

   // Index of the type bit in the word that controls a given bank.
   function automatic int type_bit(input int bank);
      return (bank == 0) ? 0 : 1;
   endfunction

endpackage

// File: rtl/outcfg_sync.sv
module outcfg_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("outcfg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("outcfg_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/outcfg_shifter.sv
module outcfg_shifter #(
   parameter int CFG_W = 10,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_rise,
   input  logic             lat_level,
   input  logic             lat_rise,
   input  logic             din,
   output logic [CFG_W-1:0] word,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             dout
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if ((1 << CNT_W) <= CFG_W) begin : g_bad_cnt
      $error("outcfg_shifter: CNT_W too narrow for CFG_W");
   end

   logic do_shift;
   assign do_shift = sclk_rise && !lat_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (do_shift) begin
         word <= {word[CFG_W-2:0], din};
      end
   end

   // Saturating count of bits shifted since the last latch edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (lat_rise) begin
         bit_cnt <= '0;
      end else if (do_shift && bit_cnt != CNT_MAX) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign dout = word[CFG_W-1];

endmodule

// File: rtl/outcfg_hold.sv
module outcfg_hold
   import outcfg_pkg::*;
#(
   parameter int N_BANK       = 4,
   parameter int OUT_PER_BANK = 2,
   parameter int CFG_W        = 10,
   parameter int CNT_W        = 4,
   parameter int N_OUT        = N_BANK * OUT_PER_BANK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  logic [CFG_W-1:0] shift_word,
   input  logic [CNT_W-1:0] bit_cnt,
   input  logic             gen,
   output logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] out_pecl,
   output logic             cnt_err,
   output logic             loaded
);

   localparam int TYPE_BITS = 2;

   if (CFG_W != N_OUT + TYPE_BITS) begin : g_bad_w
      $error("outcfg_hold: CFG_W must equal N_OUT + 2");
   end

   logic [CFG_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= '0;
         loaded  <= 1'b0;
         cnt_err <= 1'b0;
      end else if (apply) begin
         held    <= shift_word;
         loaded  <= 1'b1;
         cnt_err <= (bit_cnt != CNT_W'(CFG_W));
      end
   end

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      sig_type_e bank_ty;
      assign bank_ty = loaded ? sig_type_e'(held[type_bit(b)]) : SIG_LVDS;
      for (genvar k = 0; k < OUT_PER_BANK; k++) begin : g_out
         localparam int IDX = b * OUT_PER_BANK + k;
         assign out_en[IDX]   = loaded && gen && held[IDX + TYPE_BITS];
         assign out_pecl[IDX] = (bank_ty == SIG_PECL);
      end
   end

endmodule

// File: rtl/outcfg_ctrl.sv
module outcfg_ctrl
   import outcfg_pkg::*;
#(
   parameter int N_BANK       = 4,
   parameter int OUT_PER_BANK = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ser_clk,
   input  logic                           ser_din,
   input  logic                           ser_latch,
   input  logic                           glob_en,
   output logic [N_BANK*OUT_PER_BANK-1:0] out_en,
   output logic [N_BANK*OUT_PER_BANK-1:0] out_pecl,
   output logic                           ser_dout,
   output logic                           cnt_err
);

   localparam int N_OUT = N_BANK * OUT_PER_BANK;
   localparam int CFG_W = N_OUT + 2;
   localparam int CNT_W = $clog2(CFG_W + 1);

   if (N_BANK < 2) begin : g_bad_banks
      $error("outcfg_ctrl: need bank A plus at least one other bank");
   end
   if (OUT_PER_BANK < 1) begin : g_bad_opb
      $error("outcfg_ctrl: OUT_PER_BANK must be at least 1");
   end

   pin_bus_t pins_raw, pins_s;
   assign pins_raw = '{sclk: ser_clk, sdin: ser_din, slat: ser_latch, gen: glob_en};

   outcfg_sync #(
      .WIDTH  ($bits(pin_bus_t)),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   logic sclk_q, lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         sclk_q <= pins_s.sclk;
         lat_q  <= pins_s.slat;
      end
   end

   logic sclk_rise, lat_rise, lat_s, gen_s;
   assign sclk_rise = pins_s.sclk & ~sclk_q;
   assign lat_rise  = pins_s.slat & ~lat_q;
   assign lat_s     = pins_s.slat;
   assign gen_s     = pins_s.gen;

   logic [CFG_W-1:0] sh_word;
   logic [CNT_W-1:0] bit_cnt;
   logic             loaded;

   outcfg_shifter #(
      .CFG_W (CFG_W),
      .CNT_W (CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_rise (sclk_rise),
      .lat_level (lat_s),
      .lat_rise  (lat_rise),
      .din       (pins_s.sdin),
      .word      (sh_word),
      .bit_cnt   (bit_cnt),
      .dout      (ser_dout)
   );

   outcfg_hold #(
      .N_BANK       (N_BANK),
      .OUT_PER_BANK (OUT_PER_BANK),
      .CFG_W        (CFG_W),
      .CNT_W        (CNT_W),
      .N_OUT        (N_OUT)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .apply      (lat_rise),
      .shift_word (sh_word),
      .bit_cnt    (bit_cnt),
      .gen        (gen_s),
      .out_en     (out_en),
      .out_pecl   (out_pecl),
      .cnt_err    (cnt_err),
      .loaded     (loaded)
   );

endmodule

// File: rtl/outcfg_ctrl_chk.sv
module outcfg_ctrl_chk #(
   parameter int CFG_W = 10,
   parameter int N_OUT = 8,
   parameter int OPB   = 2,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             apply,
   input logic             shift_rise,
   input logic             lat_s,
   input logic             gen_s,
   input logic             loaded,
   input logic [CFG_W-1:0] sh_word,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [N_OUT-1:0] out_en,
   input logic [N_OUT-1:0] out_pecl,
   input logic             cnt_err
);

   // R3
   hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(gen_s) && !$past(apply)) |-> ($stable(out_en) && $stable(out_pecl)));

   // R4
   apply_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (out_en == ($past(sh_word[CFG_W-1:2]) & {N_OUT{gen_s}})));

   // R5
   apply_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> ((out_pecl[OPB-1:0] == {OPB{$past(sh_word[0])}}) &&
                 (out_pecl[N_OUT-1:OPB] == {(N_OUT-OPB){$past(sh_word[1])}})));

   // R6
   glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_s |-> (out_en == '0));

   // R8
   count_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (cnt_err == ($past(bit_cnt) != CNT_W'(CFG_W))));

   // R9
   latch_shift_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_rise && lat_s) |=> ($stable(sh_word) && $stable(bit_cnt)));

   // R10
   unloaded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> ((out_en == '0) && (out_pecl == '0)));

endmodule

bind outcfg_ctrl outcfg_ctrl_chk #(
   .CFG_W (CFG_W),
   .N_OUT (N_OUT),
   .OPB   (OUT_PER_BANK),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .apply      (lat_rise),
   .shift_rise (sclk_rise),
   .lat_s      (lat_s),
   .gen_s      (gen_s),
   .loaded     (loaded),
   .sh_word    (sh_word),
   .bit_cnt    (bit_cnt),
   .out_en     (out_en),
   .out_pecl   (out_pecl),
   .cnt_err    (cnt_err)
);

// File: tb/outcfg_ctrl_bench.sv
`timescale 1ns/1ps
module outcfg_ctrl_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic p_clk = 0, p_din = 0, p_lat = 0, p_gen = 0;
   logic [7:0] out_en, out_pecl;
   logic ser_dout, cnt_err;

   always #2 clk = ~clk;

   outcfg_ctrl u_outcfg_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (p_clk),
      .ser_din   (p_din),
      .ser_latch (p_lat),
      .glob_en   (p_gen),
      .out_en    (out_en),
      .out_pecl  (out_pecl),
      .ser_dout  (ser_dout),
      .cnt_err   (cnt_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: pins seen two cycles late, edges from history.
   logic [3:0] hist[$];            // {clk, din, lat, gen}
   logic [9:0] m_sh, m_word;
   int         m_cnt;
   bit         m_loaded, m_err, m_gen;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {4'h0, 4'h0, 4'h0, 4'h0};
         m_sh = '0; m_word = '0; m_cnt = 0;
         m_loaded = 0; m_err = 0; m_gen = 0;
      end else begin
         logic [3:0] cur, old;
         hist.push_back({p_clk, p_din, p_lat, p_gen});
         while (hist.size() > 4) void'(hist.pop_front());
         cur = hist[1];
         old = hist[0];
         if (cur[3] && !old[3] && !cur[1]) begin
            m_sh = {m_sh[8:0], cur[2]};
            if (m_cnt < 15) m_cnt++;
         end
         if (cur[1] && !old[1]) begin
            m_err = (m_cnt != 10);
            m_word = m_sh;
            m_loaded = 1;
            m_cnt = 0;
         end
         m_gen = hist[2][0];
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] e_en, e_ty;
         e_en = (m_loaded && m_gen) ? m_word[9:2] : 8'h00;
         e_ty = m_loaded ? {{6{m_word[1]}}, {2{m_word[0]}}} : 8'h00;
         chk("R4", "model out_en", out_en, e_en);      // also R3, R6, R10
         chk("R5", "model out_pecl", out_pecl, e_ty);
         chk("R7", "model ser_dout", ser_dout, m_sh[9]); // R2 shift order
         chk("R8", "model cnt_err", cnt_err, m_err);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [9:0] w, input int n, output logic [9:0] rb);
      rb = '0;
      for (int i = 0; i < n; i++) begin
         p_din = w[9-i];
         p_clk = 0;
         cyc(4);
         rb = {rb[8:0], ser_dout};
         p_clk = 1;
         cyc(4);
         p_clk = 0;
      end
   endtask

   task automatic latch();
      p_lat = 1;
      cyc(6);
      p_lat = 0;
      cyc(4);
   endtask

   initial begin
      logic [9:0] rb;
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1", "reset out_en", out_en, 8'h00);
      chk("R1", "reset out_pecl", out_pecl, 8'h00);
      chk("R1", "reset ser_dout", ser_dout, 1'b0);
      chk("R1", "reset cnt_err", cnt_err, 1'b0);

      p_gen = 1;
      cyc(4);
      send(10'b11_0110_1001, 10, rb);
      chk("R10", "no latch yet", out_en, 8'h00);
      latch();
      chk("R4", "word1 enables", out_en, 8'hDA);
      chk("R5", "word1 types", out_pecl, 8'h03);
      chk("R8", "word1 count ok", cnt_err, 1'b0);

      // R7 readback of the previous word, R2 MSB first
      send(10'b00_1111_0010, 10, rb);
      chk("R7", "readback word1", rb, 10'b11_0110_1001);
      chk("R3", "unchanged before latch", out_en, 8'hDA);
      latch();
      chk("R4", "word2 enables", out_en, 8'h3C);
      chk("R5", "word2 types", out_pecl, 8'hFC);

      // R6 global enable off
      p_gen = 0;
      cyc(4);
      chk("R6", "glob off enables", out_en, 8'h00);
      chk("R6", "glob off types", out_pecl, 8'hFC);
      p_gen = 1;
      cyc(4);
      chk("R6", "glob on again", out_en, 8'h3C);

      // R8 short word applied as it stands
      send(10'b10_0000_0111, 7, rb);
      latch();
      chk("R8", "short count flag", cnt_err, 1'b1);
      chk("R8", "short word enables", out_en, 8'h50);
      chk("R8", "short word types", out_pecl, 8'h00);
      send(10'h3FF, 10, rb);
      latch();
      chk("R8", "full count clears", cnt_err, 1'b0);
      chk("R4", "all ones enables", out_en, 8'hFF);

      // R9 shift clock while latch high
      p_lat = 1;
      p_din = 0;
      cyc(6);
      for (int i = 0; i < 3; i++) begin
         p_clk = 1; cyc(4);
         p_clk = 0; cyc(4);
      end
      p_lat = 0;
      cyc(6);
      chk("R9", "readback unchanged", ser_dout, 1'b1);
      latch();
      chk("R9", "no bits counted", cnt_err, 1'b1);
      chk("R9", "word unchanged", out_en, 8'hFF);

      // Collision: latch edge and glob_en fall together
      send(10'b00_0000_0110, 10, rb);
      p_lat = 1;
      p_gen = 0;
      cyc(6);
      p_lat = 0;
      cyc(4);
      chk("R6", "collision enables", out_en, 8'h00);
      chk("R5", "collision types", out_pecl, 8'hFC);
      p_gen = 1;
      cyc(4);
      chk("R4", "after collision", out_en, 8'h01);

      // R10 after a fresh reset
      rst_n = 0;
      cyc(3);
      rst_n = 1;
      cyc(4);
      chk("R10", "fresh reset enables", out_en, 8'h00);
      send(10'h3FF, 10, rb);
      chk("R10", "shifted not latched", out_en, 8'h00);
      chk("R10", "shifted not latched type", out_pecl, 8'h00);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule